// File: doc/BRIEF.md
# Command Mailbox Register Target

This block is the target side of a small command mailbox. A management controller reaches it over a byte-wide register bus made of an 8-bit address, write data, a write strobe, a read strobe and registered read data. The controller fills the inbound message bytes with a command code and a 32-bit argument. It then writes the trigger value to the kick register, and the block hands the request to an internal responder as a single-cycle start pulse.

The responder later returns a one-cycle done pulse together with a 32-bit result. The block stores the result in the outbound message bytes and sets a sticky alert flag in the status byte. The flag drives an active-low alert pin unless the mask bit in the control byte is set. The controller clears the flag by writing a one to it.

Top module: `mbx_target`

## Requirements
- R1: After reset every register reads zero, `alert_n` is 1 and `rsp_start` is 0.
- R2: The control byte (0x01) and inbound bytes 0..7 (0x38..0x3F) are read/write. A read strobe sampled at a clock edge puts the addressed byte on `bus_rdata` at that edge, and the value holds until the next read.
- R3: Writing 0x01 to the kick register (0x40) raises `rsp_start` for exactly one cycle, starting at the edge that samples the write. While it is high, `rsp_cmd` equals inbound byte 0 and `rsp_arg` equals inbound bytes 4..1, with byte 1 as the least significant byte.
- R4: Writing any value other than 0x01 to 0x40 does not start a command. Address 0x40 reads as zero.
- R5: A `rsp_done` pulse loads `rsp_result` into outbound bytes 1..4 (0x31..0x34), with byte 1 as the least significant byte. Outbound bytes 0, 5, 6 and 7 read zero.
- R6: A `rsp_done` pulse sets status bit 1, so the status byte at 0x02 reads 0x02.
- R7: Writing the status byte with bit 1 = 1 clears the flag, and writing 0 there leaves it set. When a done pulse and a clearing write arrive in the same cycle, the flag stays set.
- R8: `alert_n` is low exactly when status bit 1 is 1 and control bit 4 is 0.
- R9: Reads of unmapped addresses return zero. Bus writes to the outbound bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rsp_start | output | 1 | One-cycle command start to the responder |
| rsp_cmd | output | 8 | Command code (inbound byte 0) |
| rsp_arg | output | 32 | Command argument (inbound bytes 4..1) |
| rsp_done | input | 1 | Responder completion pulse |
| rsp_result | input | 32 | Responder result, sampled with `rsp_done` |
| alert_n | output | 1 | Active-low completion alert |

## Verification
Read data is due one edge after the read strobe. A monitor keyed on that strobe compares it at the following falling edge against a queue that the read task fills. The start pulse is due at the edge that samples the kick write, so it is checked at the next falling edge, and its absence is confirmed one cycle later. A done pulse updates the status flag, the outbound bytes and `alert_n` at the edge that samples it. Each of these is checked at the next falling edge or through a read issued after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int WORD_B   = WORD_W / BYTE_W;

    localparam logic [7:0] A_CTRL  = 8'h01;
    localparam logic [7:0] A_STAT  = 8'h02;
    localparam logic [7:0] A_OUTB  = 8'h30;
    localparam logic [7:0] A_INB   = 8'h38;
    localparam logic [7:0] A_KICK  = 8'h40;
    localparam logic [7:0] KICK_GO = 8'h01;

    localparam int MASK_BIT  = 4;
    localparam int FLAG_BIT  = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [WORD_W-1:0] arg;
    } mbx_req_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [7:0]        addr;
        logic [BYTE_W-1:0] wdata;
    } mbx_bus_t;

    function automatic logic hit(input mbx_bus_t b, input logic [7:0] a);
        return b.wr && (b.addr == a);
    endfunction
endpackage

// File: rtl/mbx_status.sv
module mbx_status
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic              done,
    input  logic              mask,
    output logic [BYTE_W-1:0] sts_byte,
    output logic              alert_n
);
    logic flag;

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (done)    flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    always_comb begin
        sts_byte           = '0;
        sts_byte[FLAG_BIT] = flag;
    end

    assign alert_n = ~(flag & ~mask);

    p_done_sets_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> flag);
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !done) |=> !flag);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int MSG_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mbx_bus_t          bus,
    input  logic [BYTE_W-1:0] sts_byte,
    input  logic              done,
    input  logic [WORD_W-1:0] result,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] ctrl,
    output mbx_req_t          req,
    output logic              start
);
    logic [BYTE_W-1:0] inb  [MSG_N];
    logic [BYTE_W-1:0] outb [MSG_N];
    logic [BYTE_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst)                  ctrl <= '0;
        else if (hit(bus, A_CTRL)) ctrl <= bus.wdata;
    end

    for (genvar i = 0; i < MSG_N; i++) begin : g_msg
        always_ff @(posedge clk) begin
            if (rst)                          inb[i] <= '0;
            else if (hit(bus, A_INB + 8'(i))) inb[i] <= bus.wdata;
        end
        if (i >= 1 && i <= WORD_B) begin : g_load
            always_ff @(posedge clk) begin
                if (rst)       outb[i] <= '0;
                else if (done) outb[i] <= result[BYTE_W*(i-1) +: BYTE_W];
            end
        end else begin : g_zero
            assign outb[i] = '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus.addr == A_CTRL) rd_mux = ctrl;
        if (bus.addr == A_STAT) rd_mux = sts_byte;
        for (int i = 0; i < MSG_N; i++) begin
            if (bus.addr == A_OUTB + 8'(i)) rd_mux = outb[i];
            if (bus.addr == A_INB  + 8'(i)) rd_mux = inb[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (bus.rd) rdata <= rd_mux;
    end

    always_ff @(posedge clk) begin
        if (rst) start <= 1'b0;
        else     start <= hit(bus, A_KICK) && (bus.wdata == KICK_GO);
    end

    always_comb begin
        req.cmd = inb[0];
        for (int b = 0; b < WORD_B; b++)
            req.arg[BYTE_W*b +: BYTE_W] = inb[b+1];
    end

    p_one_shot_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
    p_start_cause_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(bus.wr && bus.addr == A_KICK && bus.wdata == KICK_GO));
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(bus.rd) |-> $stable(rdata));
endmodule

// File: rtl/mbx_target.sv
module mbx_target
    import mbx_pkg::*;
#(
    parameter int MSG_N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        rsp_start,
    output logic [7:0]  rsp_cmd,
    output logic [31:0] rsp_arg,
    input  logic        rsp_done,
    input  logic [31:0] rsp_result,
    output logic        alert_n
);
    mbx_bus_t          bus;
    mbx_req_t          req;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] sts_byte;
    logic              clr_req;

    assign bus = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};
    assign clr_req = hit(bus, A_STAT) && bus_wdata[FLAG_BIT];

    mbx_regs #(.MSG_N(MSG_N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .sts_byte (sts_byte),
        .done     (rsp_done),
        .result   (rsp_result),
        .rdata    (bus_rdata),
        .ctrl     (ctrl),
        .req      (req),
        .start    (rsp_start)
    );

    mbx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_req  (clr_req),
        .done     (rsp_done),
        .mask     (ctrl[MASK_BIT]),
        .sts_byte (sts_byte),
        .alert_n  (alert_n)
    );

    assign rsp_cmd = req.cmd;
    assign rsp_arg = req.arg;

    p_masked_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl[MASK_BIT] |-> alert_n);
    p_alert_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !ctrl[MASK_BIT] && !hit(bus, A_CTRL)) |=> !alert_n);
endmodule

// File: tb/tb_mbx_target.sv
module tb_mbx_target;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rsp_start;
    logic [7:0]  rsp_cmd;
    logic [31:0] rsp_arg;
    logic        rsp_done = 1'b0;
    logic [31:0] rsp_result = '0;
    logic        alert_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_q = 1'b0;

    always #2.5 clk = ~clk;

    mbx_target dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rsp_start(rsp_start), .rsp_cmd(rsp_cmd), .rsp_arg(rsp_arg),
        .rsp_done(rsp_done), .rsp_result(rsp_result), .alert_n(alert_n)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_q <= bus_rd;

    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                check(32'(bus_rdata), 32'hDEAD, "R2 unexpected read");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(32'(bus_rdata), 32'(e.val), e.tag);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        x.val = e; x.tag = tag;
        exp_q.push_back(x);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic done(input logic [31:0] r);
        rsp_done = 1'b1; rsp_result = r;
        @(negedge clk);
        rsp_done = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(alert_n, 1'b1, "R1 alert_n");
        check(rsp_start, 1'b0, "R1 rsp_start");
        rd(8'h01, 8'h00, "R1 ctrl");
        rd(8'h02, 8'h00, "R1 status");
        rd(8'h38, 8'h00, "R1 inbound0");
        rd(8'h31, 8'h00, "R1 outbound1");

        wr(8'h01, 8'h5A);
        rd(8'h01, 8'h5A, "R2 ctrl rw");
        wr(8'h01, 8'h00);
        wr(8'h3F, 8'h80);
        wr(8'h38, 8'h03);
        wr(8'h39, 8'h78); wr(8'h3A, 8'h56); wr(8'h3B, 8'h34); wr(8'h3C, 8'h12);
        rd(8'h3F, 8'h80, "R2 inbound7");
        rd(8'h3A, 8'h56, "R2 inbound2");

        // R4: other values written to kick do nothing
        wr(8'h40, 8'h02);
        check(rsp_start, 1'b0, "R4 no start a");
        @(negedge clk);
        check(rsp_start, 1'b0, "R4 no start b");
        rd(8'h40, 8'h00, "R4 kick reads zero");

        // R3: kick value 0x01
        wr(8'h40, 8'h01);
        check(rsp_start, 1'b1, "R3 start high");
        check(32'(rsp_cmd), 32'h03, "R3 cmd");
        check(rsp_arg, 32'h12345678, "R3 arg");
        @(negedge clk);
        check(rsp_start, 1'b0, "R3 start one cycle");

        done(32'hCAFEF00D);
        check(alert_n, 1'b0, "R8 alert low");
        rd(8'h02, 8'h02, "R6 status set");
        rd(8'h31, 8'h0D, "R5 outbound1");
        rd(8'h34, 8'hCA, "R5 outbound4");
        rd(8'h32, 8'hF0, "R5 outbound2");
        rd(8'h30, 8'h00, "R5 outbound0");
        rd(8'h35, 8'h00, "R5 outbound5");

        wr(8'h31, 8'hFF);
        rd(8'h31, 8'h0D, "R9 outbound write ignored");
        rd(8'h10, 8'h00, "R9 unmapped 0x10");
        rd(8'h41, 8'h00, "R9 unmapped 0x41");

        wr(8'h02, 8'h00);
        rd(8'h02, 8'h02, "R7 write zero keeps flag");
        wr(8'h02, 8'h02);
        check(alert_n, 1'b1, "R8 alert released");
        rd(8'h02, 8'h00, "R7 w1c clears");

        wr(8'h01, 8'h10);
        done(32'h1);
        check(alert_n, 1'b1, "R8 masked");
        rd(8'h02, 8'h02, "R6 set while masked");
        wr(8'h01, 8'h00);
        check(alert_n, 1'b0, "R8 unmasked");

        // R7: done and clear in the same cycle, set wins
        wr(8'h02, 8'h02);
        bus_addr = 8'h02; bus_wdata = 8'h02; bus_wr = 1'b1;
        rsp_done = 1'b1; rsp_result = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0; rsp_done = 1'b0;
        rd(8'h02, 8'h02, "R7 set beats clear");

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R2 all reads returned");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule